// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Register

This block holds the two-word command that software fills in to send an interrupt to another processor. The upper word carries an 8-bit target number. The lower word carries the vector, the delivery mode, the destination mode, the level and trigger flags and a two-bit shorthand code. It also has a busy flag that hardware sets and clears. A write to the lower word starts a send. The block then offers one message on a valid/ready channel and holds it there until the fabric takes it.

The register stays busy until the fabric returns a completion pulse. While busy, the block ignores any write to the lower word in full, so an in-flight command can never be overwritten. The block handles only explicit destinations. A write that asks for the self or broadcast shorthands stores its fields but sends nothing. It raises an error flag that stays set until reset.

Top module: `ipi_cmd_reg`

## Requirements
- R1: After reset both words read as zero, msg_valid is 0 and err_flag is 0.
- R2: A write with wr_sel=1 stores wr_data[31:24] as the destination at any time, busy or not. Reading with rd_sel=1 returns the destination in bits 31:24 and zeros in bits 23:0.
- R3: A write with wr_sel=0 while not busy, with shorthand bits 19:18 equal to 0, stores the fields. From the next cycle, read bit 12 (busy) is 1 and msg_valid is 1.
- R4: The message carries the stored destination on msg_dest. It carries the lower-word fields as follows: vector from bits 7:0, mode from bits 10:8, destination mode from bit 11, level from bit 14 and trigger from bit 15.
- R5: While msg_valid is 1 and msg_ready is 0, the message and msg_valid hold steady. One cycle after a handshake msg_valid is 0, so each launch gives exactly one message.
- R6: A write with wr_sel=0 while busy has no effect. The read value and the message outputs stay unchanged, and no further message is sent.
- R7: The value written to bit 12 is ignored. Bits 13, 16, 17 and 31:20 of the lower word always read 0.
- R8: A cpl_valid pulse clears busy on the next cycle only if busy is set and no message is pending. Otherwise it has no effect.
- R9: A lower-word write while idle with shorthand 1, 2 or 3 stores the fields, leaves busy at 0 and sends no message. It sets err_flag, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 lower word, 1 upper word |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read target: 0 lower word, 1 upper word |
| rd_data | output | 32 | Read data of the selected word |
| cpl_valid | input | 1 | Completion pulse from the fabric |
| err_flag | output | 1 | Sticky unsupported-shorthand flag |
| msg_valid | output | 1 | Outgoing message valid |
| msg_ready | input | 1 | Fabric accepts the message |
| msg_dest | output | 8 | Message destination |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Message delivery mode |
| msg_dest_logical | output | 1 | Message destination mode |
| msg_level | output | 1 | Message level flag |
| msg_trigger | output | 1 | Message trigger flag |

## Verification
A busy flag that was lost or stuck would show within one cycle. The next lower-word write would either launch a second message or be dropped, and either result is visible on msg_valid and in read bit 12. Field routing faults show on the message outputs in the cycle after a launch. The sweep covers every delivery mode, every shorthand and both destination modes, so each bit lands in a distinct position. A completion pulse that arrives before the handshake, or while idle, must leave the read value unchanged on the following cycle.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
    localparam int WORD_W  = 32;
    localparam int VEC_W   = 8;
    localparam int MODE_W  = 3;
    localparam int SH_W    = 2;
    localparam int DEST_W  = 8;

    localparam int VEC_LSB   = 0;
    localparam int MODE_LSB  = VEC_LSB + VEC_W;
    localparam int DM_BIT    = MODE_LSB + MODE_W;
    localparam int BUSY_BIT  = DM_BIT + 1;
    localparam int LEVEL_BIT = 14;
    localparam int TRIG_BIT  = 15;
    localparam int SH_LSB    = 18;
    localparam int DEST_LSB  = WORD_W - DEST_W;

    typedef struct packed {
        logic [SH_W-1:0]   shorthand;
        logic              trigger;
        logic              level;
        logic              dest_logical;
        logic [MODE_W-1:0] mode;
        logic [VEC_W-1:0]  vector;
    } cmd_fields_t;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              trigger;
        logic              level;
        logic              dest_logical;
        logic [MODE_W-1:0] mode;
        logic [VEC_W-1:0]  vector;
    } ipi_msg_t;

    function automatic logic [WORD_W-1:0] pack_low(cmd_fields_t f, logic busy);
        logic [WORD_W-1:0] w;
        w = '0;
        w[VEC_LSB +: VEC_W]   = f.vector;
        w[MODE_LSB +: MODE_W] = f.mode;
        w[DM_BIT]             = f.dest_logical;
        w[BUSY_BIT]           = busy;
        w[LEVEL_BIT]          = f.level;
        w[TRIG_BIT]           = f.trigger;
        w[SH_LSB +: SH_W]     = f.shorthand;
        return w;
    endfunction
endpackage

// File: rtl/ipi_field_unpack.sv
module ipi_field_unpack
    import ipi_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output cmd_fields_t       fields,
    output logic              explicit_dest
);
    logic unused_rsvd;

    always_comb begin
        fields.vector       = word[VEC_LSB +: VEC_W];
        fields.mode         = word[MODE_LSB +: MODE_W];
        fields.dest_logical = word[DM_BIT];
        fields.level        = word[LEVEL_BIT];
        fields.trigger      = word[TRIG_BIT];
        fields.shorthand    = word[SH_LSB +: SH_W];
        explicit_dest       = (fields.shorthand == '0);
    end

    // busy bit and reserved bits carry no information from software
    assign unused_rsvd = ^{word[BUSY_BIT], word[13], word[17:16], word[DEST_LSB-1:SH_LSB+SH_W],
                           word[WORD_W-1:DEST_LSB]};
endmodule

// File: rtl/ipi_msg_hold.sv
module ipi_msg_hold
    import ipi_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  ipi_msg_t msg_in,
    input  logic     ready,
    output logic     valid,
    output ipi_msg_t msg_out
);
    typedef struct packed {
        logic     valid;
        ipi_msg_t msg;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (hold_q.valid && ready) begin
            hold_d.valid = 1'b0;
        end
        if (load) begin
            hold_d.valid = 1'b1;
            hold_d.msg   = msg_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign valid   = hold_q.valid;
    assign msg_out = hold_q.msg;

    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(msg_out)));

    assert_load_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !valid);
endmodule

// File: rtl/ipi_cmd_reg.sv
module ipi_cmd_reg
    import ipi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [WORD_W-1:0] rd_data,
    input  logic              cpl_valid,
    output logic              err_flag,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [DEST_W-1:0] msg_dest,
    output logic [VEC_W-1:0]  msg_vector,
    output logic [MODE_W-1:0] msg_mode,
    output logic              msg_dest_logical,
    output logic              msg_level,
    output logic              msg_trigger
);
    typedef struct packed {
        cmd_fields_t       low;
        logic              busy;
        logic [DEST_W-1:0] dest;
        logic              err;
    } reg_state_t;

    reg_state_t  st_d, st_q;
    cmd_fields_t wr_fields;
    logic        wr_explicit;
    logic        wr_low;
    logic        accept;
    logic        launch;
    ipi_msg_t    msg_in;
    ipi_msg_t    msg_out;

    ipi_field_unpack u_unpack (
        .word          (wr_data),
        .fields        (wr_fields),
        .explicit_dest (wr_explicit)
    );

    always_comb begin
        wr_low = wr_en && !wr_sel;
        accept = wr_low && !st_q.busy;
        launch = accept && wr_explicit;

        msg_in.dest         = st_q.dest;
        msg_in.trigger      = wr_fields.trigger;
        msg_in.level        = wr_fields.level;
        msg_in.dest_logical = wr_fields.dest_logical;
        msg_in.mode         = wr_fields.mode;
        msg_in.vector       = wr_fields.vector;

        st_d = st_q;
        if (wr_en && wr_sel) begin
            st_d.dest = wr_data[DEST_LSB +: DEST_W];
        end
        if (accept) begin
            st_d.low = wr_fields;
            if (wr_explicit) begin
                st_d.busy = 1'b1;
            end else begin
                st_d.err = 1'b1;
            end
        end
        if (cpl_valid && st_q.busy && !msg_valid) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    ipi_msg_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (launch),
        .msg_in  (msg_in),
        .ready   (msg_ready),
        .valid   (msg_valid),
        .msg_out (msg_out)
    );

    always_comb begin
        if (rd_sel) begin
            rd_data = '0;
            rd_data[DEST_LSB +: DEST_W] = st_q.dest;
        end else begin
            rd_data = pack_low(st_q.low, st_q.busy);
        end
    end

    assign err_flag         = st_q.err;
    assign msg_dest         = msg_out.dest;
    assign msg_vector       = msg_out.vector;
    assign msg_mode         = msg_out.mode;
    assign msg_dest_logical = msg_out.dest_logical;
    assign msg_level        = msg_out.level;
    assign msg_trigger      = msg_out.trigger;

    assert_busy_from_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> $past(wr_en && !wr_sel));

    assert_busy_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && wr_low) |=> $stable(st_q.low));

    assert_valid_needs_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> st_q.busy);

    assert_cpl_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && st_q.busy && !msg_valid) |=> !st_q.busy);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);
endmodule

// File: tb/ipi_cmd_reg_tb.sv
module ipi_cmd_reg_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        cpl_valid = 1'b0;
    logic        err_flag;
    logic        msg_valid;
    logic        msg_ready = 1'b0;
    logic [7:0]  msg_dest;
    logic [7:0]  msg_vector;
    logic [2:0]  msg_mode;
    logic        msg_dest_logical;
    logic        msg_level;
    logic        msg_trigger;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ipi_cmd_reg u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .cpl_valid(cpl_valid), .err_flag(err_flag),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest),
        .msg_vector(msg_vector), .msg_mode(msg_mode), .msg_dest_logical(msg_dest_logical),
        .msg_level(msg_level), .msg_trigger(msg_trigger)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_low(input logic [31:0] d, input logic busy);
        return (d & 32'h000C_CFFF) | (32'(busy) << 12);
    endfunction

    task automatic write(input logic sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_low(output logic [31:0] v);
        rd_sel = 1'b0; #1 v = rd_data;
    endtask

    task automatic read_high(output logic [31:0] v);
        rd_sel = 1'b1; #1 v = rd_data;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, d, d2, held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        read_low(v);  chk("R1 low reset", v, 32'h0);
        read_high(v); chk("R1 high reset", v, 32'h0);
        chk("R1 valid reset", {31'b0, msg_valid}, 32'h0);
        chk("R1 err reset", {31'b0, err_flag}, 32'h0);

        for (int sh = 0; sh < 4; sh++) begin
            for (int mode = 0; mode < 8; mode++) begin
                for (int k = 0; k < 2; k++) begin
                    logic [7:0] dest, vec;
                    dest = 8'(mode * 37 + k * 101 + sh * 13 + 1);
                    vec  = 8'(mode * 29 + k * 128 + sh * 7 + 16);
                    write(1'b1, {dest, 24'hA5A5A5});
                    read_high(v); chk("R2 dest store", v, {dest, 24'h0});
                    d = {12'hFFF, 2'(sh), 2'b11, 1'(k), 1'(~k), 1'b1, 1'(mode & 1),
                         1'(k), 3'(mode), vec};
                    write(1'b0, d);
                    if (sh == 0) begin
                        read_low(v); chk("R3 R7 stored busy", v, exp_low(d, 1'b1));
                        chk("R3 valid", {31'b0, msg_valid}, 32'h1);
                        chk("R4 dest", {24'b0, msg_dest}, {24'b0, dest});
                        chk("R4 fields", {16'b0, msg_trigger, msg_level, msg_dest_logical, msg_mode, msg_vector},
                            {16'b0, d[15], d[14], d[11], d[10:8], d[7:0]});
                        held = {16'b0, msg_trigger, msg_level, msg_dest_logical, msg_mode, msg_vector};
                        // R2: upper word writable while busy; message keeps launch value
                        write(1'b1, {~dest, 24'h0});
                        read_high(v); chk("R2 dest while busy", v, {~dest, 24'h0});
                        chk("R4 dest held", {24'b0, msg_dest}, {24'b0, dest});
                        d2 = ~d & 32'hFFF3_FFFF;
                        write(1'b0, d2);
                        read_low(v); chk("R6 busy write ignored", v, exp_low(d, 1'b1));
                        chk("R6 msg unchanged", {16'b0, msg_trigger, msg_level, msg_dest_logical, msg_mode, msg_vector}, held);
                        if (mode == 0) begin
                            @(negedge clk); cpl_valid = 1'b1;
                            @(negedge clk); cpl_valid = 1'b0;
                            read_low(v); chk("R8 early cpl ignored", v, exp_low(d, 1'b1));
                        end
                        for (int w = 0; w < mode % 3; w++) begin
                            @(negedge clk);
                            chk("R5 valid held", {31'b0, msg_valid}, 32'h1);
                        end
                        @(negedge clk); msg_ready = 1'b1;
                        @(negedge clk); msg_ready = 1'b0;
                        chk("R5 single message", {31'b0, msg_valid}, 32'h0);
                        read_low(v); chk("R8 busy until cpl", v, exp_low(d, 1'b1));
                        @(negedge clk); cpl_valid = 1'b1;
                        @(negedge clk); cpl_valid = 1'b0;
                        read_low(v); chk("R8 cpl clears", v, exp_low(d, 1'b0));
                        @(negedge clk); cpl_valid = 1'b1;
                        @(negedge clk); cpl_valid = 1'b0;
                        read_low(v); chk("R8 idle cpl ignored", v, exp_low(d, 1'b0));
                        chk("R9 err clear on explicit", {31'b0, err_flag}, 32'h0);
                    end else begin
                        read_low(v); chk("R9 stored not busy", v, exp_low(d, 1'b0));
                        chk("R9 no message", {31'b0, msg_valid}, 32'h0);
                        chk("R9 err set", {31'b0, err_flag}, 32'h1);
                    end
                end
            end
        end

        // R9: error survives a later successful send
        write(1'b0, 32'h0000_0042);
        chk("R9 err sticky", {31'b0, err_flag}, 32'h1);
        chk("R3 send after error", {31'b0, msg_valid}, 32'h1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule